// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block moves an 18-bit word between two ports, A and B. Each direction has its own storage path with an output enable, a latch enable and a stage clock. The latch enable and the stage clock together set the mode of the storage. With the latch enable high, data passes straight through. With the latch enable low and no rising stage-clock edge, the stored word is held. With the latch enable low, a rising stage-clock edge loads the input word. The A-to-B output enable is active high. The B-to-A output enable is active low.

The design is synchronous to a system clock `clk`. The stage clocks `ck_ab` and `ck_ba` are sampled on `clk`, and a rising edge is a sample of 0 followed by a sample of 1. Each stage clock is tracked by a two-state machine. State `CK_LOW` moves to `CK_HIGH` when the sample is 1, and `CK_HIGH` moves to `CK_LOW` when the sample is 0. A load is allowed only when the machine is in `CK_LOW` and the sample is 1. From this and the latch enable, each storage path picks one of three modes: `CELL_PASS`, `CELL_HOLD` or `CELL_LOAD`.

Each bidirectional pin group is modelled as an input word, an output word and an output-enable flag. A drive flag on each port tells whether an outside driver is active. When `KEEPER` is 1, a keeper register stands in for a floating port. It holds the last level on the port, whether that level came from the outside driver or from the block's own output.

Top module: `bus_xcvr18`

## Requirements
- R1: The data path is WIDTH bits wide (default 18) in each direction, and every bit uses the same logic.
- R2: While `le_ab` is 1, `b_out` equals the A input word in the same cycle (transparent mode).
- R3: While `le_ab` is 0 and `ck_ab` shows no rising edge, `b_out` keeps its stored word. This covers `ck_ab` held high, held low, or falling. If `ck_ab` was high when `le_ab` fell, the stored word is the one present on A in the last cycle that `le_ab` was 1.
- R4: While `le_ab` is 0, a rising edge of `ck_ab` loads the A word, and `b_out` shows it from the `clk` edge that sampled `ck_ab` as 1.
- R5: `b_oe` is 1 exactly when `oe_ab` is 1. When `b_oe` is 0 the B port floats, but storage still loads and holds as usual.
- R6: The B-to-A path mirrors A-to-B, using `le_ba`, `ck_ba`, `a_out` and `a_oe`. Its output enable is active low: `a_oe` is 1 exactly when `oe_ba_n` is 0.
- R7: The two directions are independent: activity on one path leaves the other path's output word unchanged.
- R8: With `KEEPER`=1, a port whose drive flag is 0 presents the last level on that port to its path. That level is the block's own output if the block drove the port, otherwise the last externally driven word. The kept level updates one `clk` cycle after the port's level.
- R9: A synchronous `rst` clears both stored words and the keepers to 0. A stage clock that is already high when reset ends causes no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| oe_ab | input | 1 | Enable for driving the B port, active high |
| le_ab | input | 1 | A-to-B latch enable |
| ck_ab | input | 1 | A-to-B stage clock; loads on a rising edge |
| oe_ba_n | input | 1 | Enable for driving the A port, active low |
| le_ba | input | 1 | B-to-A latch enable |
| ck_ba | input | 1 | B-to-A stage clock; loads on a rising edge |
| a_in | input | WIDTH | Level seen on the A pins |
| a_drv | input | 1 | 1 when an outside driver holds the A pins |
| a_out | output | WIDTH | Word the block drives onto A |
| a_oe | output | 1 | 1 when the block drives A |
| b_in | input | WIDTH | Level seen on the B pins |
| b_drv | input | 1 | 1 when an outside driver holds the B pins |
| b_out | output | WIDTH | Word the block drives onto B |
| b_oe | output | 1 | 1 when the block drives B |

## Verification
The assertions check four things on every cycle:
- a load pulse only follows a low-to-high stage-clock sample;
- storage keeps its word whenever it is neither open nor loading;
- storage takes the input word on each open or loading cycle;
- a floating keeper stays put, and a driven keeper copies the block's own output.

Some behaviour only the bench scenarios can show. These include the full mode table in both directions with the opposite enable polarities, and holding with the stage clock high after the latch closes. They also include loading while the port is disabled, the absence of a load at reset release, independence between the directions, and the keeper supplying a floating port's level.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Sampled level history of one stage clock
    typedef enum logic {
        CK_LOW  = 1'b0,
        CK_HIGH = 1'b1
    } ck_state_e;

    // Operating mode of one storage path in a given cycle
    typedef enum logic [1:0] {
        CELL_PASS = 2'd0,
        CELL_HOLD = 2'd1,
        CELL_LOAD = 2'd2
    } cell_mode_e;

endpackage

// File: rtl/xcvr_edge_track.sv
module xcvr_edge_track
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ck_i,
    output logic rise_o
);

    ck_state_e state_q;
    ck_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LOW:  state_d = ck_i ? CK_HIGH : CK_LOW;
            CK_HIGH: state_d = ck_i ? CK_HIGH : CK_LOW;
            default: state_d = CK_HIGH;
        endcase
    end

    // State register: reset to CK_HIGH so a clock already high at reset release is not an edge
    always_ff @(posedge clk) begin
        if (rst) state_q <= CK_HIGH;
        else     state_q <= state_d;
    end

    // Output logic
    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            CK_LOW:  rise_o = ck_i;
            CK_HIGH: rise_o = 1'b0;
            default: rise_o = 1'b0;
        endcase
    end

    // R4: a load pulse only when the previous sample was low
    p_rise_after_low_r4: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> (ck_i && !$past(ck_i)));

endmodule

// File: rtl/xcvr_store_path.sv
module xcvr_store_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             le_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] dout_o
);

    cell_mode_e       mode;
    logic [WIDTH-1:0] q;

    // Mode selection: the latch enable takes priority over the stage clock
    always_comb begin
        if (le_i)        mode = CELL_PASS;
        else if (load_i) mode = CELL_LOAD;
        else             mode = CELL_HOLD;
    end

    // R1: identical storage per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else begin
                unique case (mode)
                    CELL_PASS: q[i] <= d_i[i];
                    CELL_LOAD: q[i] <= d_i[i];
                    CELL_HOLD: q[i] <= q[i];
                    default:   q[i] <= q[i];
                endcase
            end
        end
    end

    // Output: open latch shows the input, otherwise the stored word
    always_comb begin
        unique case (mode)
            CELL_PASS: dout_o = d_i;
            default:   dout_o = q;
        endcase
    end

    // R3: closed and not loading keeps the stored word
    p_hold_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (!le_i && !load_i) |=> (dout_o == $past(dout_o)) || le_i);

    // R4: a load stores the input word
    p_load_takes_r4: assert property (@(posedge clk) disable iff (rst)
        (!le_i && load_i) |=> (q == $past(d_i)));

    // R2: an open latch tracks the input, so closing it holds the last word
    p_pass_tracks_r2: assert property (@(posedge clk) disable iff (rst)
        le_i |=> (q == $past(d_i)));

endmodule

// File: rtl/xcvr_pin_keeper.sv
module xcvr_pin_keeper #(
    parameter int WIDTH  = 18,
    parameter bit KEEPER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drv_i,
    input  logic [WIDTH-1:0] pin_i,
    input  logic             own_oe_i,
    input  logic [WIDTH-1:0] own_d_i,
    output logic [WIDTH-1:0] eff_o
);

    if (KEEPER) begin : g_keep
        logic [WIDTH-1:0] kept;

        // R8: remember the last level actually on the port
        always_ff @(posedge clk) begin
            if (rst)           kept <= '0;
            else if (own_oe_i) kept <= own_d_i;
            else if (drv_i)    kept <= pin_i;
            else               kept <= kept;
        end

        assign eff_o = drv_i ? pin_i : kept;

        // R8: a floating, undriven port keeps its level
        p_keep_float_r8: assert property (@(posedge clk) disable iff (rst)
            (!drv_i && !own_oe_i) |=> (kept == $past(kept)));

        // R8: the block's own drive is what the keeper remembers
        p_keep_own_r8: assert property (@(posedge clk) disable iff (rst)
            own_oe_i |=> (kept == $past(own_d_i)));
    end else begin : g_plain
        logic unused_keep;
        assign unused_keep = ^{clk, rst, drv_i, own_oe_i, own_d_i};
        assign eff_o = pin_i;
    end

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18 #(
    parameter int WIDTH  = 18,
    parameter bit KEEPER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_ab,
    input  logic             le_ab,
    input  logic             ck_ab,
    input  logic             oe_ba_n,
    input  logic             le_ba,
    input  logic             ck_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_drv,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_drv,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic             rise_ab;
    logic             rise_ba;

    // R5 / R6: opposite enable polarities
    assign b_oe = oe_ab;
    assign a_oe = ~oe_ba_n;

    // Port keepers
    xcvr_pin_keeper #(.WIDTH(WIDTH), .KEEPER(KEEPER)) u_keep_a (
        .clk      (clk),
        .rst      (rst),
        .drv_i    (a_drv),
        .pin_i    (a_in),
        .own_oe_i (a_oe),
        .own_d_i  (a_out),
        .eff_o    (a_eff)
    );

    xcvr_pin_keeper #(.WIDTH(WIDTH), .KEEPER(KEEPER)) u_keep_b (
        .clk      (clk),
        .rst      (rst),
        .drv_i    (b_drv),
        .pin_i    (b_in),
        .own_oe_i (b_oe),
        .own_d_i  (b_out),
        .eff_o    (b_eff)
    );

    // A-to-B path
    xcvr_edge_track u_edge_ab (
        .clk    (clk),
        .rst    (rst),
        .ck_i   (ck_ab),
        .rise_o (rise_ab)
    );

    xcvr_store_path #(.WIDTH(WIDTH)) u_path_ab (
        .clk    (clk),
        .rst    (rst),
        .le_i   (le_ab),
        .load_i (rise_ab),
        .d_i    (a_eff),
        .dout_o (b_out)
    );

    // B-to-A path
    xcvr_edge_track u_edge_ba (
        .clk    (clk),
        .rst    (rst),
        .ck_i   (ck_ba),
        .rise_o (rise_ba)
    );

    xcvr_store_path #(.WIDTH(WIDTH)) u_path_ba (
        .clk    (clk),
        .rst    (rst),
        .le_i   (le_ba),
        .load_i (rise_ba),
        .d_i    (b_eff),
        .dout_o (a_out)
    );

    // R7: an idle B-to-A path keeps the A output steady
    p_ba_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!le_ba && !rise_ba) |=> (a_out == $past(a_out)) || le_ba);

endmodule

// File: tb/test_bus_xcvr18.sv
module test_bus_xcvr18;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic         oe_ab, le_ab, ck_ab, oe_ba_n, le_ba, ck_ba;
    logic [W-1:0] a_in, b_in;
    logic         a_drv, b_drv;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    bus_xcvr18 #(.WIDTH(W), .KEEPER(1'b1)) i_bus_xcvr18 (
        .clk(clk), .rst(rst),
        .oe_ab(oe_ab), .le_ab(le_ab), .ck_ab(ck_ab),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ck_ba(ck_ba),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe)
    );

    // Vector: {le, ck, en, data, expected word, expected output enable}
    localparam int NV = 13;
    localparam logic [39:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 1'b1, 18'h15555, 18'h15555, 1'b1},
        {1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA, 1'b1},
        {1'b0, 1'b0, 1'b1, 18'h00F0F, 18'h2AAAA, 1'b1},
        {1'b0, 1'b1, 1'b1, 18'h00F0F, 18'h00F0F, 1'b1},
        {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h00F0F, 1'b1},
        {1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h00F0F, 1'b1},
        {1'b0, 1'b0, 1'b0, 18'h12345, 18'h00F0F, 1'b0},
        {1'b0, 1'b1, 1'b0, 18'h12345, 18'h12345, 1'b0},
        {1'b0, 1'b1, 1'b1, 18'h00000, 18'h12345, 1'b1},
        {1'b1, 1'b1, 1'b1, 18'h00001, 18'h00001, 1'b1},
        {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h00001, 1'b1},
        {1'b0, 1'b0, 1'b1, 18'h20000, 18'h00001, 1'b1},
        {1'b0, 1'b1, 1'b1, 18'h20000, 18'h20000, 1'b1}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // dir 0: A to B (R2..R5), dir 1: B to A (R6)
    task automatic run_dir(input bit dir);
        logic         prev_ck;
        logic [W-1:0] other;
        prev_ck = dir ? ck_ba : ck_ab;
        other   = dir ? b_out : a_out;
        for (int i = 0; i < NV; i++) begin
            logic le, ck, en, eo;
            logic [W-1:0] d, ew;
            string tw;
            {le, ck, en, d, ew, eo} = VEC[i];
            tw = le ? "R2" : ((ck && !prev_ck) ? "R4" : "R3");
            @(negedge clk);
            if (dir) begin
                le_ba = le; ck_ba = ck; oe_ba_n = ~en; b_in = d;
            end else begin
                le_ab = le; ck_ab = ck; oe_ab = en; a_in = d;
            end
            tick();
            if (dir) begin
                chk({"R6 word, mode ", tw}, a_out, ew);
                chk("R6 active-low enable", {17'd0, a_oe}, {17'd0, eo});
            end else begin
                chk({tw, " word"}, b_out, ew);
                chk("R5 enable", {17'd0, b_oe}, {17'd0, eo});
            end
            prev_ck = ck;
        end
        // R7: the idle direction did not move
        if (dir) chk("R7 B output steady", b_out, other);
        else     chk("R7 A output steady", a_out, other);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        oe_ab = 1'b0; le_ab = 1'b0; ck_ab = 1'b1;
        oe_ba_n = 1'b1; le_ba = 1'b0; ck_ba = 1'b0;
        a_in = 18'h3FFFF; a_drv = 1'b1;
        b_in = 18'h00000; b_drv = 1'b0;
        repeat (3) tick();

        // R9: reset state
        chk("R9 reset b_out", b_out, '0);
        chk("R9 reset a_out", a_out, '0);
        chk("R5 b_oe low with oe_ab=0", {17'd0, b_oe}, 18'd0);
        chk("R6 a_oe low with oe_ba_n=1", {17'd0, a_oe}, 18'd0);

        // R9: clock already high at reset release does not load
        @(negedge clk); rst = 1'b0;
        tick();
        tick();
        chk("R9 no load at release", b_out, '0);

        // R4: low then high loads
        @(negedge clk); ck_ab = 1'b0;
        tick();
        chk("R3 low clock holds", b_out, '0);
        @(negedge clk); ck_ab = 1'b1;
        tick();
        chk("R4 rise loads", b_out, 18'h3FFFF);

        // R1..R6 table in both directions
        run_dir(1'b0);
        @(negedge clk);
        oe_ab = 1'b0; a_drv = 1'b0; b_drv = 1'b1;
        run_dir(1'b1);

        // R8: keeper holds an externally driven A word
        @(negedge clk);
        oe_ba_n = 1'b1; le_ba = 1'b0; ck_ba = 1'b0;
        a_drv = 1'b1; a_in = 18'h0ABCD; le_ab = 1'b1; oe_ab = 1'b1;
        tick();
        chk("R2 pass before float", b_out, 18'h0ABCD);
        @(negedge clk); a_drv = 1'b0; a_in = 18'h3FFFF;
        tick();
        chk("R8 floating A keeps driven level", b_out, 18'h0ABCD);

        // R8: keeper holds the block's own A drive
        @(negedge clk);
        b_drv = 1'b1; b_in = 18'h11111; le_ba = 1'b1; oe_ba_n = 1'b0; oe_ab = 1'b0;
        tick();
        chk("R6 A driven from B", a_out, 18'h11111);
        @(negedge clk); oe_ba_n = 1'b1; le_ba = 1'b0;
        tick();
        chk("R8 floating A keeps own level", b_out, 18'h11111);

        summary();
    end

endmodule